// File: doc/BRIEF.md
# Power-Up Protocol Selector with Answer-to-Reset Sender

This block sits at the pin edge of a secure memory that can talk either a synchronous two-wire serial protocol or an asynchronous character protocol used by smart-card readers. It watches the external reset pin after power-on. If the pin is high from the start, which is the case when it is left unbonded and pulled up, or if it rises too soon, the device stays in the synchronous two-wire mode. If the pin is held low while the clock runs for at least a programmable number of cycles and then rises, the asynchronous mode is selected.

In asynchronous mode, after a fixed delay, the block sends an answer-to-reset string of configurable length on the shared I/O line. The string is taken from a register loaded at configuration time. Each character has one low start bit, eight data bits sent least significant bit first, one even-parity bit and a high guard time. Every bit lasts one elementary time unit, a parameterised number of input clocks (372 by default). The I/O output is an open-drain drive-low enable. The choice of mode lasts until the next power-on reset.

Top module: `atr_mode_select`

## Requirements
- R1: After power-on reset, if `rst_pin` is high from the start or is held low for fewer than COLD_MIN rising clock edges after `por_n` is released, `async_mode` stays 0 and `io_drive_low` is never asserted.
- R2: If `rst_pin` is held low for at least COLD_MIN rising edges after `por_n` is released and then rises, `async_mode` becomes 1 on the second rising edge after the edge at which `rst_pin` is first sampled high.
- R3: Once the synchronous mode is chosen, it stays chosen until the next power-on reset, whatever `rst_pin` does later.
- R4: Once the asynchronous mode is chosen, `async_mode` stays 1 until the next power-on reset. The answer-to-reset string is sent only once, and later activity on `rst_pin` produces no further traffic on the I/O line.
- R5: In asynchronous mode the I/O line stays released (`io_drive_low` = 0) until the first start bit. That start bit begins ATR_DELAY + 2 rising edges after the edge at which `rst_pin` is first sampled high.
- R6: Each character is sent as 10 + GUARD_ETUS bit slots, where `io_drive_low` = 1 means a logic 0 on the line. Slot 0 is the start bit (driven low). Slots 1 to 8 carry data bits 0 to 7. Slot 9 carries the parity bit, chosen so that the data bits plus parity contain an even number of ones. The remaining GUARD_ETUS slots are released.
- R7: Every bit slot lasts exactly ETU_CLKS clock cycles (default 372).
- R8: Character k of the string is `atr_data[8k+7:8k]`. Character 0 is sent first, and the characters follow one another with no gap beyond the guard slots.
- R9: `atr_done` rises on the clock edge that ends the last guard slot of the last character and then stays 1, with the I/O line released.
- R10: Driving `por_n` low clears `async_mode`, `io_drive_low` and `atr_done` at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | External clock: carrier for the bit timing and sampling clock for the reset pin |
| por_n | input | 1 | Power-on reset, active low, asserted asynchronously |
| rst_pin | input | 1 | External reset pin level (pulled high when unconnected) |
| atr_data | input | 8*ATR_BYTES | Answer-to-reset string; character 0 in the low byte |
| async_mode | output | 1 | 1 when the asynchronous character protocol has been selected |
| io_drive_low | output | 1 | Open-drain enable: 1 pulls the shared I/O line low, 0 releases it |
| atr_done | output | 1 | 1 once the whole answer-to-reset string has been sent |

## Verification
The bench sweeps the length of the initial low period of the reset pin across the cold-reset threshold, from a pin that is high at once up to several cycles past the limit. A selector that is off by one cycle at the threshold picks the wrong protocol on exactly one step of that sweep. On every asynchronous run the whole line waveform is rebuilt from the string contents and checked at the first and last cycle of each bit slot. This catches a wrong bit order, a parity of the wrong sense, a slot that is one clock short or long, a missing guard time and a late or early first start bit. Further runs try to force a second selection after each mode has been settled, and a power-on reset is applied in the middle of a character; a design that is not sticky, or that resets only on the clock, shows traffic or stale outputs in those windows.

// File: rtl/atr_sel_pkg.sv
package atr_sel_pkg;

  // depth of the reset-release and pin-sampling flop chains
  localparam int unsigned SYNC_DEPTH = 2;

  // protocol selector states
  typedef enum logic [2:0] {
    MS_SENSE = 3'd0,  // watching the reset pin after power-up
    MS_SYNC  = 3'd1,  // two-wire mode locked
    MS_WAIT  = 3'd2,  // asynchronous mode, waiting before the first character
    MS_SEND  = 3'd3,  // answer-to-reset in progress
    MS_DONE  = 3'd4   // answer-to-reset finished
  } mode_state_t;

  // logic level of bit slot idx of one character (1 = released line)
  function automatic logic frame_level(input logic [7:0] chr, input int idx);
    logic lvl;
    if (idx == 0)
      lvl = 1'b0;                 // start bit
    else if (idx <= 8)
      lvl = chr[3'(idx - 1)];     // data, least significant first
    else if (idx == 9)
      lvl = ^chr;                 // even parity over data plus parity
    else
      lvl = 1'b1;                 // guard time
    return lvl;
  endfunction

endpackage

// File: rtl/atr_por_sync.sv
module atr_por_sync
  import atr_sel_pkg::*;
(
  input  logic clk,
  input  logic por_n,
  output logic rst_n
);

  logic [SYNC_DEPTH-1:0] chain_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) chain_q <= '0;
    else        chain_q <= {chain_q[SYNC_DEPTH-2:0], 1'b1};
  end

  assign rst_n = chain_q[SYNC_DEPTH-1];

endmodule

// File: rtl/atr_pin_sync.sv
module atr_pin_sync
  import atr_sel_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic pin_q
);

  logic [SYNC_DEPTH-1:0] stage_q;

  // reset to low so a high pin is only seen after real samples
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= {stage_q[SYNC_DEPTH-2:0], pin};
  end

  assign pin_q = stage_q[SYNC_DEPTH-1];

endmodule

// File: rtl/atr_mode_fsm.sv
module atr_mode_fsm
  import atr_sel_pkg::*;
#(
  parameter int unsigned COLD_MIN  = 400,
  parameter int unsigned ATR_DELAY = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_hi,
  input  logic tx_done,
  output logic tx_start,
  output logic async_mode
);

  localparam int unsigned LOW_W  = $clog2(COLD_MIN + 1);
  localparam int unsigned WAIT_W = $clog2(ATR_DELAY + 1);
  localparam logic [LOW_W-1:0]  LOW_MAX   = LOW_W'(COLD_MIN);
  localparam logic [WAIT_W-1:0] WAIT_LAST = WAIT_W'(ATR_DELAY - 1);

  mode_state_t       state_q, state_d;
  logic [LOW_W-1:0]  low_q, low_d;
  logic [WAIT_W-1:0] wait_q, wait_d;

  // next-state logic
  always_comb begin
    state_d  = state_q;
    low_d    = low_q;
    wait_d   = wait_q;
    tx_start = 1'b0;
    unique case (state_q)
      MS_SENSE: begin
        if (pin_hi) begin
          wait_d  = '0;
          state_d = (low_q == LOW_MAX) ? MS_WAIT : MS_SYNC;
        end else if (low_q != LOW_MAX) begin
          low_d = low_q + 1'b1;
        end
      end
      MS_WAIT: begin
        if (wait_q == WAIT_LAST) begin
          tx_start = 1'b1;
          state_d  = MS_SEND;
        end else begin
          wait_d = wait_q + 1'b1;
        end
      end
      MS_SEND: begin
        if (tx_done) state_d = MS_DONE;
      end
      MS_SYNC, MS_DONE: state_d = state_q;
      default: state_d = MS_SENSE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= MS_SENSE;
      low_q   <= '0;
      wait_q  <= '0;
    end else begin
      state_q <= state_d;
      low_q   <= low_d;
      wait_q  <= wait_d;
    end
  end

  assign async_mode = (state_q == MS_WAIT) || (state_q == MS_SEND) ||
                      (state_q == MS_DONE);

  // R3: two-wire choice is final
  a_r3_sync_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == MS_SYNC) |=> (state_q == MS_SYNC));

  // R4: asynchronous choice is final
  a_r4_async_locked: assert property (@(posedge clk) disable iff (!rst_n)
    async_mode |=> async_mode);

  // R4: a single answer-to-reset request per power-up
  a_r4_one_request: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |=> (state_q == MS_SEND) && !tx_start);

endmodule

// File: rtl/atr_frame_tx.sv
module atr_frame_tx
  import atr_sel_pkg::*;
#(
  parameter int unsigned ETU_CLKS   = 372,
  parameter int unsigned GUARD_ETUS = 2,
  parameter int unsigned ATR_BYTES  = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [8*ATR_BYTES-1:0] atr_data,
  output logic                   drive_low,
  output logic                   done
);

  localparam int unsigned FRAME_BITS = 10 + GUARD_ETUS;
  localparam int unsigned ETU_W  = $clog2(ETU_CLKS);
  localparam int unsigned BIT_W  = $clog2(FRAME_BITS);
  localparam int unsigned BYTE_W = (ATR_BYTES > 1) ? $clog2(ATR_BYTES) : 1;
  localparam logic [ETU_W-1:0]  ETU_LAST  = ETU_W'(ETU_CLKS - 1);
  localparam logic [BIT_W-1:0]  BIT_LAST  = BIT_W'(FRAME_BITS - 1);
  localparam logic [BYTE_W-1:0] BYTE_LAST = BYTE_W'(ATR_BYTES - 1);

  // split the string into characters
  logic [7:0] chr_arr [ATR_BYTES];
  for (genvar g = 0; g < ATR_BYTES; g++) begin : g_chr
    assign chr_arr[g] = atr_data[8*g +: 8];
  end

  logic              busy_q, busy_d;
  logic              drive_q, drive_d;
  logic              done_q, done_d;
  logic [ETU_W-1:0]  etu_q, etu_d;
  logic [BIT_W-1:0]  bit_q, bit_d;
  logic [BYTE_W-1:0] byte_q, byte_d;
  logic [7:0]        cur_chr;

  assign cur_chr = chr_arr[byte_q];

  // next-state logic
  always_comb begin
    busy_d  = busy_q;
    drive_d = drive_q;
    done_d  = done_q;
    etu_d   = etu_q;
    bit_d   = bit_q;
    byte_d  = byte_q;
    if (!busy_q) begin
      if (start && !done_q) begin
        busy_d  = 1'b1;
        etu_d   = '0;
        bit_d   = '0;
        byte_d  = '0;
        drive_d = 1'b1;               // first start bit
      end
    end else if (etu_q == ETU_LAST) begin
      etu_d = '0;
      if (bit_q == BIT_LAST) begin
        bit_d = '0;
        if (byte_q == BYTE_LAST) begin
          busy_d  = 1'b0;
          done_d  = 1'b1;
          drive_d = 1'b0;
        end else begin
          byte_d  = byte_q + 1'b1;
          drive_d = 1'b1;             // next start bit
        end
      end else begin
        bit_d   = bit_q + 1'b1;
        drive_d = !frame_level(cur_chr, int'(bit_q) + 1);
      end
    end else begin
      etu_d = etu_q + 1'b1;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      drive_q <= 1'b0;
      done_q  <= 1'b0;
      etu_q   <= '0;
      bit_q   <= '0;
      byte_q  <= '0;
    end else begin
      busy_q  <= busy_d;
      drive_q <= drive_d;
      done_q  <= done_d;
      etu_q   <= etu_d;
      bit_q   <= bit_d;
      byte_q  <= byte_d;
    end
  end

  assign drive_low = drive_q;
  assign done      = done_q;

  // R7: the line only changes at a slot boundary
  a_r7_slot_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && (etu_q != ETU_LAST)) |=> $stable(drive_q));

  // R6: a character opens with the line pulled low
  a_r6_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> drive_q);

  // R6: guard slots leave the line released
  a_r6_guard_free: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && (int'(bit_q) >= 10)) |-> !drive_q);

  // R9: finished flag holds and the line stays released
  a_r9_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> done_q && !drive_q && !busy_q);

endmodule

// File: rtl/atr_mode_select.sv
module atr_mode_select
  import atr_sel_pkg::*;
#(
  parameter int unsigned ETU_CLKS   = 372,
  parameter int unsigned COLD_MIN   = 400,
  parameter int unsigned ATR_DELAY  = 1000,
  parameter int unsigned GUARD_ETUS = 2,
  parameter int unsigned ATR_BYTES  = 8
) (
  input  logic                   clk,
  input  logic                   por_n,
  input  logic                   rst_pin,
  input  logic [8*ATR_BYTES-1:0] atr_data,
  output logic                   async_mode,
  output logic                   io_drive_low,
  output logic                   atr_done
);

  logic rst_n;
  logic pin_hi;
  logic tx_start;
  logic tx_done;

  atr_por_sync u_por (
    .clk   (clk),
    .por_n (por_n),
    .rst_n (rst_n)
  );

  atr_pin_sync u_pin (
    .clk   (clk),
    .rst_n (rst_n),
    .pin   (rst_pin),
    .pin_q (pin_hi)
  );

  atr_mode_fsm #(
    .COLD_MIN  (COLD_MIN),
    .ATR_DELAY (ATR_DELAY)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .pin_hi     (pin_hi),
    .tx_done    (tx_done),
    .tx_start   (tx_start),
    .async_mode (async_mode)
  );

  atr_frame_tx #(
    .ETU_CLKS   (ETU_CLKS),
    .GUARD_ETUS (GUARD_ETUS),
    .ATR_BYTES  (ATR_BYTES)
  ) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (tx_start),
    .atr_data  (atr_data),
    .drive_low (io_drive_low),
    .done      (tx_done)
  );

  assign atr_done = tx_done;

  // R1 R5: no traffic on the line outside the asynchronous mode
  a_r5_quiet_unless_async: assert property (@(posedge clk) disable iff (!rst_n)
    !async_mode |-> !io_drive_low);

  // R9: completion implies the asynchronous mode
  a_r9_done_async: assert property (@(posedge clk) disable iff (!rst_n)
    atr_done |-> async_mode);

endmodule

// File: tb/atr_mode_select_test.sv
module atr_mode_select_test;

  localparam int unsigned ETU   = 5;
  localparam int unsigned COLD  = 12;
  localparam int unsigned DLY   = 7;
  localparam int unsigned GUARD = 2;
  localparam int unsigned NB    = 8;
  localparam int unsigned FB    = 10 + GUARD;

  logic          clk = 1'b0;
  logic          por_n;
  logic          rst_pin;
  logic [8*NB-1:0] atr_data;
  logic          async_mode, io_drive_low, atr_done;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;  // 50 MHz

  atr_mode_select #(
    .ETU_CLKS(ETU), .COLD_MIN(COLD), .ATR_DELAY(DLY),
    .GUARD_ETUS(GUARD), .ATR_BYTES(NB)
  ) uut (
    .clk(clk), .por_n(por_n), .rst_pin(rst_pin), .atr_data(atr_data),
    .async_mode(async_mode), .io_drive_low(io_drive_low), .atr_done(atr_done)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // expected drive-low value of frame slot p of the whole string
  function automatic logic exp_drive(input logic [8*NB-1:0] d, input int p);
    logic [7:0] c;
    int j;
    c = d[8*(p / FB) +: 8];
    j = p % FB;
    if (j == 0) return 1'b1;
    if (j <= 8) return ~c[j-1];
    if (j == 9) return ~(^c);
    return 1'b0;
  endfunction

  // power up, hold the pin low for 'lowlen' edges, then raise it
  task automatic power_up(input int lowlen);
    por_n   = 1'b0;
    rst_pin = (lowlen == 0);
    repeat (3) @(negedge clk);
    chk("R10 reset state", {61'd0, async_mode, io_drive_low, atr_done}, 64'd0);
    por_n = 1'b1;
    repeat (lowlen) @(negedge clk);
    chk("R1 quiet while pin low", {62'd0, async_mode, io_drive_low}, 64'd0);
    rst_pin = 1'b1;
  endtask

  // full asynchronous run; abort_at >= 0 applies a power-on reset in that slot
  task automatic async_run(input int lowlen, input logic [8*NB-1:0] d, input int abort_at);
    logic bad;
    atr_data = d;
    power_up(lowlen);
    repeat (3) @(negedge clk);
    chk("R2 async selected", {63'd0, async_mode}, 64'd1);
    repeat (DLY - 1) @(negedge clk);
    chk("R5 released before start", {63'd0, io_drive_low}, 64'd0);
    @(negedge clk);
    for (int p = 0; p < int'(NB * FB); p++) begin
      if (p == abort_at) begin
        #5 por_n = 1'b0;
        #1 chk("R10 async clear", {61'd0, async_mode, io_drive_low, atr_done}, 64'd0);
        @(negedge clk);
        return;
      end
      bad = (io_drive_low !== exp_drive(d, p));
      repeat (ETU - 1) @(negedge clk);
      if (io_drive_low !== exp_drive(d, p)) bad = 1'b1;
      if (atr_done !== 1'b0) bad = 1'b1;
      chk($sformatf("R6 R7 R8 slot %0d", p), {62'd0, bad, io_drive_low},
          {62'd0, 1'b0, exp_drive(d, p)});
      @(negedge clk);
    end
    chk("R9 done at end", {62'd0, atr_done, io_drive_low}, 64'd2);
    // R4: a second cold sequence gives nothing
    bad = 1'b0;
    rst_pin = 1'b0;
    repeat (COLD + 5) @(negedge clk) if (io_drive_low) bad = 1'b1;
    rst_pin = 1'b1;
    repeat (DLY + 4 * ETU) @(negedge clk) if (io_drive_low || !async_mode) bad = 1'b1;
    chk("R4 async sticky no repeat", {62'd0, bad, atr_done}, 64'd1);
  endtask

  task automatic sync_run(input int lowlen);
    logic bad;
    atr_data = {NB{8'h00}};   // all-zero string would pull the line hard
    power_up(lowlen);
    repeat (5) @(negedge clk);
    chk($sformatf("R1 sync chosen low=%0d", lowlen), {63'd0, async_mode}, 64'd0);
    // R3: a later cold sequence must not switch modes
    bad = 1'b0;
    rst_pin = 1'b0;
    repeat (COLD + 5) @(negedge clk) if (io_drive_low || async_mode) bad = 1'b1;
    rst_pin = 1'b1;
    repeat (DLY + 2 * FB * ETU) @(negedge clk)
      if (io_drive_low || async_mode || atr_done) bad = 1'b1;
    chk("R3 sync sticky", {63'd0, bad}, 64'd0);
  endtask

  initial begin
    por_n = 1'b0;
    rst_pin = 1'b0;
    atr_data = '0;
    @(negedge clk);
    // sweep the low period across the cold-reset threshold
    for (int l = 0; l <= int'(COLD) + 3; l++) begin
      if (l >= int'(COLD))
        async_run(l, 64'h3B9F_0A55_C3E1_7F80 ^ (64'(l) * 64'h0123_4567_89AB_CDEF), -1);
      else
        sync_run(l);
    end
    async_run(COLD, 64'hFFFF_FFFF_FFFF_FFFF, -1);
    async_run(COLD, 64'h0000_0000_0000_0000, -1);
    async_run(COLD, 64'h8001_4002_2004_1008, -1);
    async_run(COLD + 1, 64'h1234_5678_9ABC_DEF0, 2 * int'(FB) + 4);
    // R2: after the abort a fresh power-up still works
    async_run(COLD, 64'hA5A5_5A5A_F00F_0FF0, -1);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule